// File: doc/BRIEF.md
# Process-Corner Speed Calibration Controller

This block calibrates an on-chip quiescent-current monitor to the process corner of the die before any current measurement runs. When the test-enable input goes high, it opens a window of a fixed number of reference-clock cycles. During that window it counts the edges of a free-running speed-monitor clock, such as a ring oscillator. The oscillator count crosses into the reference domain through a level request/acknowledge handshake. The count is then captured while it is frozen.

The count is compared against a set of ascending bounds, which places the die in one of several speed classes. A faster die leaks more, so its class gives the measurement counter a faster count clock, which keeps short discharge times resolvable. The same class also picks the pass/fail threshold handed to the decision logic. The count clock is produced as a one-cycle enable pulse from a divider, not as a gated clock.

Dropping test-enable ends the test session at once and clears the ready flag. Raising it again starts a fresh calibration.

Top module: `spdcal_ctrl`

## Requirements
- R1: After reset, `cal_done`, `cnt_en`, `div_sel` and `thresh` are all zero.
- R2: A calibration starts while `test_en` is high. `cal_done` does not rise before `test_en` has been high for at least `WIN_CYC` consecutive reference cycles.
- R3: The speed class equals the number of bounds `BOUND_BASE + k*BOUND_STEP` (k = 0 .. NCLS-2) that the oscillator count reaches or exceeds. `div_sel` is then `NCLS-1` minus the class, so the fastest class divides by 1 and the slowest by 2^(NCLS-1).
- R4: `thresh` equals `TH_BASE + class*TH_STEP` for the same class that sets `div_sel`.
- R5: While `cal_done` is high, `cnt_en` is a single-cycle pulse that repeats every 2^`div_sel` reference cycles. While `cal_done` is low, `cnt_en` stays low.
- R6: Driving `test_en` low clears `cal_done` on the next cycle. This holds during a calibration as well: an aborted calibration never raises `cal_done` and leaves `div_sel` and `thresh` at their previous values.
- R7: Each new rise of `test_en` performs a new measurement. A changed oscillator speed then yields the new class.
- R8: The oscillator count saturates at its all-ones value instead of wrapping. A count beyond 2^`CNT_W` therefore selects the fastest class.
- R9: While `cal_done` stays high, `div_sel` and `thresh` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (external test) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| osc_clk | input | 1 | Speed-monitor oscillator clock |
| test_en | input | 1 | Test session enable; high starts calibration |
| div_sel | output | $clog2(NCLS) | log2 of the selected count-clock divide ratio |
| cnt_en | output | 1 | Divided count-clock enable pulse |
| thresh | output | TH_W | Pass/fail threshold for the selected class |
| cal_done | output | 1 | Calibration complete; count enable running |

## Verification
A wrong class inside the block shows at the ports as a mismatched pair of `div_sel` and `thresh`. That mismatch appears in the first cycle `cal_done` is high, and it is compared against a class the bench derives from the oscillator period. A broken handshake or capture shows up as a class that is off for oscillator speeds placed well away from every bound. A broken counter saturation shows up as a slow class for a very fast oscillator.

A divider fault shows as a wrong number of `cnt_en` pulses within one calibrated session. A sequencer fault shows as `cal_done` arriving early, surviving a dropped `test_en`, or rising after an aborted run, each visible within a cycle or a window length.

// File: rtl/spdcal_pkg.sv
`timescale 1ns/1ps
package spdcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WIN,
        ST_DRAIN,
        ST_LOAD,
        ST_READY
    } spd_state_e;

    // Ascending speed-class bound k
    function automatic int unsigned class_bound(input int unsigned k,
                                                input int unsigned base,
                                                input int unsigned step);
        return base + k * step;
    endfunction

endpackage

// File: rtl/spdcal_sync.sv
`timescale 1ns/1ps
module spdcal_sync #(
    parameter int STG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STG-1:0] sh_q;
    logic [STG-1:0] sh_d;

    always_comb begin
        sh_d = {sh_q[STG-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STG-1];
endmodule

// File: rtl/spdcal_osc_cnt.sv
`timescale 1ns/1ps
module spdcal_osc_cnt #(
    parameter int CNT_W    = 12,
    parameter int SYNC_STG = 2
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             gate,
    output logic             ack,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             gate_d1;
        logic [CNT_W-1:0] cnt;
    } osc_reg_t;

    osc_reg_t r_q, r_d;
    logic     gate_s;

    spdcal_sync #(.STG(SYNC_STG)) u_gate_sync (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .d     (gate),
        .q     (gate_s)
    );

    always_comb begin
        r_d         = r_q;
        r_d.gate_d1 = gate_s;
        if (gate_s && !r_q.gate_d1) begin
            r_d.cnt = '0;
        end else if (gate_s && (r_q.cnt != CNT_MAX)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ack   = r_q.gate_d1;
    assign count = r_q.cnt;
endmodule

// File: rtl/spdcal_classify.sv
`timescale 1ns/1ps
module spdcal_classify
    import spdcal_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int NCLS       = 4,
    parameter int TH_W       = 10,
    parameter int BOUND_BASE = 60,
    parameter int BOUND_STEP = 40,
    parameter int TH_BASE    = 100,
    parameter int TH_STEP    = 50
) (
    input  logic [CNT_W-1:0]         count,
    output logic [$clog2(NCLS)-1:0]  div_sel,
    output logic [TH_W-1:0]          thresh
);
    localparam int DSW = $clog2(NCLS);

    logic [NCLS-2:0] above;
    logic [DSW-1:0]  cls;

    for (genvar k = 0; k < NCLS - 1; k++) begin : g_bound
        localparam int unsigned BND = class_bound(k, BOUND_BASE, BOUND_STEP);
        assign above[k] = (count >= CNT_W'(BND));
    end

    always_comb begin
        cls = '0;
        for (int k = 0; k < NCLS - 1; k++) begin
            if (above[k]) cls = cls + 1'b1;
        end
        div_sel = DSW'(NCLS - 1) - cls;
        thresh  = TH_W'(TH_BASE) + TH_W'(cls) * TH_W'(TH_STEP);
    end
endmodule

// File: rtl/spdcal_clkdiv.sv
`timescale 1ns/1ps
module spdcal_clkdiv #(
    parameter int NCLS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [$clog2(NCLS)-1:0] div_sel,
    output logic                    en
);
    localparam int DCW = (NCLS > 2) ? NCLS - 1 : 1;

    logic [DCW-1:0] ctr_q, ctr_d;
    logic [DCW:0]   mask_w;
    logic [DCW-1:0] mask;

    always_comb begin
        mask_w = ({{DCW{1'b0}}, 1'b1} << div_sel) - 1'b1;
        mask   = mask_w[DCW-1:0];
        ctr_d  = run ? ctr_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign en = run && ((ctr_q & mask) == mask);
endmodule

// File: rtl/spdcal_ctrl.sv
`timescale 1ns/1ps
module spdcal_ctrl
    import spdcal_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int WIN_CYC    = 64,
    parameter int NCLS       = 4,
    parameter int TH_W       = 10,
    parameter int BOUND_BASE = 60,
    parameter int BOUND_STEP = 40,
    parameter int TH_BASE    = 100,
    parameter int TH_STEP    = 50,
    parameter int SYNC_STG   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    osc_clk,
    input  logic                    test_en,
    output logic [$clog2(NCLS)-1:0] div_sel,
    output logic                    cnt_en,
    output logic [TH_W-1:0]         thresh,
    output logic                    cal_done
);
    localparam int DSW   = $clog2(NCLS);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

    typedef struct packed {
        spd_state_e       st;
        logic [WIN_W-1:0] win_cnt;
        logic             gate;
        logic             abort;
        logic [DSW-1:0]   div_sel;
        logic [TH_W-1:0]  thresh;
        logic             done;
    } ctl_reg_t;

    ctl_reg_t r_q, r_d;

    logic             ack_osc;
    logic             ack_s;
    logic [CNT_W-1:0] osc_count;
    logic [DSW-1:0]   cls_div;
    logic [TH_W-1:0]  cls_th;

    spdcal_osc_cnt #(.CNT_W(CNT_W), .SYNC_STG(SYNC_STG)) u_osc (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .gate    (r_q.gate),
        .ack     (ack_osc),
        .count   (osc_count)
    );

    spdcal_sync #(.STG(SYNC_STG)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_osc),
        .q     (ack_s)
    );

    spdcal_classify #(
        .CNT_W(CNT_W), .NCLS(NCLS), .TH_W(TH_W),
        .BOUND_BASE(BOUND_BASE), .BOUND_STEP(BOUND_STEP),
        .TH_BASE(TH_BASE), .TH_STEP(TH_STEP)
    ) u_cls (
        .count   (osc_count),
        .div_sel (cls_div),
        .thresh  (cls_th)
    );

    spdcal_clkdiv #(.NCLS(NCLS)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.done),
        .div_sel (r_q.div_sel),
        .en      (cnt_en)
    );

    // Sequencer: request oscillator count, time window, drain, capture, run
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.done = 1'b0;
                if (test_en) begin
                    r_d.st    = ST_ARM;
                    r_d.gate  = 1'b1;
                    r_d.abort = 1'b0;
                end
            end
            ST_ARM: begin
                if (!test_en) begin
                    r_d.st    = ST_DRAIN;
                    r_d.gate  = 1'b0;
                    r_d.abort = 1'b1;
                end else if (ack_s) begin
                    r_d.st      = ST_WIN;
                    r_d.win_cnt = '0;
                end
            end
            ST_WIN: begin
                if (!test_en) begin
                    r_d.st    = ST_DRAIN;
                    r_d.gate  = 1'b0;
                    r_d.abort = 1'b1;
                end else if (r_q.win_cnt == WIN_LAST) begin
                    r_d.st   = ST_DRAIN;
                    r_d.gate = 1'b0;
                end else begin
                    r_d.win_cnt = r_q.win_cnt + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!test_en) r_d.abort = 1'b1;
                if (!ack_s) begin
                    r_d.st = (r_q.abort || !test_en) ? ST_IDLE : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (!test_en) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.st      = ST_READY;
                    r_d.div_sel = cls_div;
                    r_d.thresh  = cls_th;
                    r_d.done    = 1'b1;
                end
            end
            ST_READY: begin
                if (!test_en) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b0;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.gate = 1'b0;
                r_d.done = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_sel  = r_q.div_sel;
    assign thresh   = r_q.thresh;
    assign cal_done = r_q.done;
endmodule

// File: rtl/spdcal_ctrl_chk.sv
`timescale 1ns/1ps
module spdcal_ctrl_chk #(
    parameter int WIN_CYC = 64,
    parameter int NCLS    = 4,
    parameter int TH_W    = 10,
    parameter int TH_BASE = 100,
    parameter int TH_STEP = 50
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    test_en,
    input logic [$clog2(NCLS)-1:0] div_sel,
    input logic                    cnt_en,
    input logic [TH_W-1:0]         thresh,
    input logic                    cal_done
);
    localparam int HW = $clog2(WIN_CYC + 2) + 1;

    logic [HW-1:0] ten_q;
    logic [15:0]   gap_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ten_q  <= '0;
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (!test_en)       ten_q <= '0;
            else if (~&ten_q)   ten_q <= ten_q + 1'b1;
            if (!cal_done) begin
                seen_q <= 1'b0;
                gap_q  <= '0;
            end else if (cnt_en) begin
                seen_q <= 1'b1;
                gap_q  <= '0;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> (ten_q >= HW'(WIN_CYC))); // R2

    AST_NO_EN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> !cnt_en); // R5

    AST_EN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && seen_q) |-> ((gap_q + 16'd1) == (16'd1 << div_sel))); // R5

    AST_DROP_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> !cal_done); // R6

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && $past(cal_done)) |-> ($stable(div_sel) && $stable(thresh))); // R9

    AST_THRESH_MATCHES_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (thresh == TH_W'(TH_BASE) + TH_W'(NCLS - 1 - int'(div_sel)) * TH_W'(TH_STEP))); // R4
endmodule

bind spdcal_ctrl spdcal_ctrl_chk #(
    .WIN_CYC (WIN_CYC),
    .NCLS    (NCLS),
    .TH_W    (TH_W),
    .TH_BASE (TH_BASE),
    .TH_STEP (TH_STEP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .div_sel  (div_sel),
    .cnt_en   (cnt_en),
    .thresh   (thresh),
    .cal_done (cal_done)
);

// File: tb/spdcal_ctrl_bench.sv
`timescale 1ns/1ps
module spdcal_ctrl_bench;
    localparam real CLK_PERIOD = 10.0;
    localparam int  CNT_W      = 12;
    localparam int  WIN_CYC    = 64;
    localparam int  NCLS       = 4;
    localparam int  TH_W       = 10;
    localparam int  BOUND_BASE = 60;
    localparam int  BOUND_STEP = 40;
    localparam int  TH_BASE    = 100;
    localparam int  TH_STEP    = 50;
    localparam int  DSW        = $clog2(NCLS);

    typedef struct {
        int    div;
        int    th;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic osc_clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_en = 1'b0;
    logic [DSW-1:0]  div_sel;
    logic            cnt_en;
    logic [TH_W-1:0] thresh;
    logic            cal_done;

    real  osc_half = 10.0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;
    exp_t sb[$];

    spdcal_ctrl #(
        .CNT_W(CNT_W), .WIN_CYC(WIN_CYC), .NCLS(NCLS), .TH_W(TH_W),
        .BOUND_BASE(BOUND_BASE), .BOUND_STEP(BOUND_STEP),
        .TH_BASE(TH_BASE), .TH_STEP(TH_STEP)
    ) u_spdcal_ctrl (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .test_en(test_en),
        .div_sel(div_sel), .cnt_en(cnt_en), .thresh(thresh), .cal_done(cal_done)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;
    initial forever #(osc_half) osc_clk = ~osc_clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected class from the oscillator period (R3, R4, R8)
    function automatic int exp_class(input real period);
        real cnt;
        int  c;
        cnt = WIN_CYC * CLK_PERIOD / period;
        if (cnt > (2.0 ** CNT_W) - 1.0) cnt = (2.0 ** CNT_W) - 1.0;
        c = 0;
        for (int k = 0; k < NCLS - 1; k++)
            if (cnt >= real'(BOUND_BASE + k * BOUND_STEP)) c++;
        return c;
    endfunction

    // Monitor: compare the configuration presented on each cal_done rise
    initial begin
        bit prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (cal_done && !prev) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R6 unexpected cal_done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(div_sel) == e.div, {"R3 div_sel ", e.tag}, int'(div_sel), e.div);
                    chk(int'(thresh) == e.th, {"R4 thresh ", e.tag}, int'(thresh), e.th);
                end
            end
            prev = cal_done;
        end
    end

    // Driver: one calibration plus a session check
    task automatic calibrate(input real period, input string tag);
        int cls, pulses, d0, t0;
        bit early;
        cls = exp_class(period);
        osc_half = period / 2.0;
        repeat (3) @(negedge clk);
        sb.push_back('{div: NCLS - 1 - cls, th: TH_BASE + cls * TH_STEP, tag: tag});
        test_en = 1'b1;
        early = 1'b0;
        for (int i = 0; i < WIN_CYC; i++) begin
            @(negedge clk);
            if (cal_done) early = 1'b1;
        end
        chk(!early, {"R2 no early done ", tag}, int'(early), 0);
        for (int i = 0; i < 600; i++) begin
            if (cal_done) break;
            @(negedge clk);
        end
        chk(cal_done, {"R7 calibration completes ", tag}, int'(cal_done), 1);
        d0 = int'(div_sel);
        t0 = int'(thresh);
        pulses = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (cnt_en) pulses++;
        end
        chk(pulses == (64 >> d0), {"R5 enable rate ", tag}, pulses, 64 >> d0);
        chk(int'(div_sel) == d0 && int'(thresh) == t0, {"R9 config stable ", tag}, int'(thresh), t0);
        test_en = 1'b0;
        @(negedge clk);
        chk(!cal_done, {"R6 drop clears done ", tag}, int'(cal_done), 0);
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cnt_en) pulses++;
        end
        chk(pulses == 0, {"R5 no enable after drop ", tag}, pulses, 0);
        chk(int'(div_sel) == d0 && int'(thresh) == t0, {"R6 config held ", tag}, int'(div_sel), d0);
    endtask

    initial begin
        int d0, t0;
        bit rose;
        repeat (4) @(negedge clk);
        chk(!cal_done && !cnt_en, "R1 reset flags", int'(cal_done), 0);
        chk(div_sel == '0 && thresh == '0, "R1 reset config", int'(thresh), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        calibrate(20.0, "slow");
        calibrate(8.0,  "class1");

        // Aborted calibration with a fast oscillator (R6)
        d0 = int'(div_sel);
        t0 = int'(thresh);
        osc_half = 1.5;
        repeat (3) @(negedge clk);
        test_en = 1'b1;
        repeat (20) @(negedge clk);
        test_en = 1'b0;
        rose = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cal_done) rose = 1'b1;
        end
        chk(!rose, "R6 abort no done", int'(rose), 0);
        chk(int'(div_sel) == d0, "R6 abort div held", int'(div_sel), d0);
        chk(int'(thresh) == t0, "R6 abort thresh held", int'(thresh), t0);

        calibrate(5.5, "class2");
        calibrate(3.0, "fast");
        calibrate(20.0, "slow again");
        calibrate(0.155, "R8 saturate");

        chk(sb.size() == 0, "R7 all calibrations reported", sb.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000.0);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule